// File: doc/BRIEF.md
# Configuration Unlock and Device Setup Sequencer

This block sits behind a single byte-wide write port used for plug-and-play style card setup. While idle it compares every written byte against a fixed 32-byte unlock sequence. Only once the whole sequence has arrived in order does it open a configuration session. Inside that session, bytes alternate between a register index and one or two value bytes. These bytes set a card select number and choose a logical device. For the current device they also fill in three 16-bit I/O base addresses, two interrupt lines, two DMA channels and an enable bit.

Settings for a logical device are gathered in a pending record. The record is not released at once. It is committed on a one-cycle strobe when the next logical device is chosen, or when the session-ending byte arrives. Downstream decoders latch the committed record. A lock input, driven from a configuration bit, keeps the block from unlocking and drops any open session back to idle.

Top module: `cfg_unlock_seq`

## Requirements
- R1: After reset the block is idle: `in_config`, `csn_strobe` and `commit_strobe` are 0.
- R2: Each idle write that equals the expected key byte advances a key position; after 32 matches `in_config` rises. The key is 96 35 9A CD E6 F3 79 BC 5E AF 57 2B 15 8A C5 E2 F1 F8 7C 3E 9F 4F 27 13 09 84 42 A1 D0 68 34 1A. Any mismatch returns the position to the start, and the mismatching byte is not itself counted as a first key byte.
- R3: In index state, byte 0x79 ends the session (`in_config` falls). It commits the pending record if one exists; otherwise no commit strobe occurs.
- R4: Index 0x06 followed by a value byte pulses `csn_strobe` for one cycle with that byte on `csn_value`.
- R5: Index 0x15 followed by a device number commits the pending record, if any. It then opens a new record holding that device number, with all other fields zero.
- R6: Indices 0x47, 0x48 and 0x42 set I/O base 0, 1 and 2. Each takes two value bytes, high byte first, then low byte.
- R7: Indices 0x22 and 0x27 set IRQ 0 and IRQ 1 from value bits [3:0]. Indices 0x2A and 0x25 set DMA 0 and DMA 1 from bits [2:0]. Index 0x33 sets the enable flag from bit 0.
- R8: While no device is open, IRQ, DMA, enable and I/O writes change nothing. They still consume their value bytes (two for I/O), and the session returns to index state.
- R9: Any other index consumes one value byte with no effect on outputs or the record.
- R10: While `cfg_lock` is high the block is forced idle, the key position returns to the start, and writes cannot unlock it.
- R11: A successful unlock discards any pending record, so a following 0x79 produces no commit.
- R12: `commit_strobe` is high for exactly the cycle after the write that triggers it. The `commit_*` record outputs hold their value until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lock | input | 1 | Blocks unlocking and forces idle |
| wr_en | input | 1 | Byte write strobe on the configuration port |
| wr_data | input | 8 | Written byte |
| in_config | output | 1 | Configuration session open |
| csn_strobe | output | 1 | Card select number write pulse |
| csn_value | output | 8 | Card select number value |
| commit_strobe | output | 1 | Device record commit pulse |
| commit_ldn | output | 8 | Committed logical device number |
| commit_io0 | output | 16 | Committed I/O base 0 |
| commit_io1 | output | 16 | Committed I/O base 1 |
| commit_io2 | output | 16 | Committed I/O base 2 |
| commit_irq0 | output | 4 | Committed IRQ 0 |
| commit_irq1 | output | 4 | Committed IRQ 1 |
| commit_dma0 | output | 3 | Committed DMA 0 |
| commit_dma1 | output | 3 | Committed DMA 1 |
| commit_active | output | 1 | Committed enable flag |

## Verification
The bench builds the block with its defaults: a 32-byte key grown from seeds 0x96 and 0x35. At that size a mismatch can be injected at every one of the 32 key positions. All 256 index values can be swept inside a session, and all 256 value bytes can be pushed through the IRQ, DMA and enable fields, with the expected masks computed in the bench. A key byte resent at the wrong position checks that a mismatch never counts as a fresh start. The lock is raised both mid-key and mid-session.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int BYTE_W  = 8;
    localparam int IO_W    = 16;
    localparam int IRQ_W   = 4;
    localparam int DMA_W   = 3;
    localparam int NUM_IO  = 3;
    localparam int NUM_IRQ = 2;
    localparam int NUM_DMA = 2;

    // Index codes: the host software depends on these values
    localparam logic [BYTE_W-1:0] IDX_CSN   = 8'h06;
    localparam logic [BYTE_W-1:0] IDX_LDN   = 8'h15;
    localparam logic [BYTE_W-1:0] IDX_IO0   = 8'h47;
    localparam logic [BYTE_W-1:0] IDX_IO1   = 8'h48;
    localparam logic [BYTE_W-1:0] IDX_IO2   = 8'h42;
    localparam logic [BYTE_W-1:0] IDX_IRQ0  = 8'h22;
    localparam logic [BYTE_W-1:0] IDX_IRQ1  = 8'h27;
    localparam logic [BYTE_W-1:0] IDX_DMA0  = 8'h2A;
    localparam logic [BYTE_W-1:0] IDX_DMA1  = 8'h25;
    localparam logic [BYTE_W-1:0] IDX_ACT   = 8'h33;
    localparam logic [BYTE_W-1:0] CMD_LEAVE = 8'h79;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INDEX,
        ST_VAL,
        ST_VAL_LO
    } seq_state_e;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_CSN,
        FLD_LDN,
        FLD_IO,
        FLD_IRQ,
        FLD_DMA,
        FLD_ACT
    } fld_kind_e;

    typedef struct packed {
        fld_kind_e   kind;
        logic [1:0]  slot;
    } fld_sel_t;

    typedef struct packed {
        logic [BYTE_W-1:0]                ldn;
        logic [NUM_IO-1:0][IO_W-1:0]      io;
        logic [NUM_IRQ-1:0][IRQ_W-1:0]    irq;
        logic [NUM_DMA-1:0][DMA_W-1:0]    dma;
        logic                             act;
    } dev_rec_t;

    // Shift right, feeding bit0 xor bit1 into the top
    function automatic logic [BYTE_W-1:0] key_step(input logic [BYTE_W-1:0] b);
        return {b[0] ^ b[1], b[BYTE_W-1:1]};
    endfunction

endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
    import cfg_seq_pkg::*;
#(
    parameter int                KEY_LEN   = 32,
    parameter logic [BYTE_W-1:0] KEY_SEED0 = 8'h96,
    parameter logic [BYTE_W-1:0] KEY_SEED1 = 8'h35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              unlock
);
    localparam int POS_W = $clog2(KEY_LEN);
    localparam logic [POS_W-1:0] LAST = POS_W'(KEY_LEN - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } km_t;

    km_t q, d;

    // Expected key byte at a position, regenerated from the seeds
    function automatic logic [BYTE_W-1:0] key_at(input logic [POS_W-1:0] p);
        logic [BYTE_W-1:0] b;
        b = KEY_SEED1;
        for (int k = 1; k < KEY_LEN; k++) begin
            if (k < int'(p)) b = key_step(b);
        end
        return (p == '0) ? KEY_SEED0 : b;
    endfunction

    logic [BYTE_W-1:0] expect_byte;
    logic              hit;

    always_comb begin
        d           = q;
        unlock      = 1'b0;
        expect_byte = key_at(q.pos);
        hit         = byte_vld && (byte_in == expect_byte);
        if (clr) begin
            d.pos = '0;
        end else if (byte_vld) begin
            if (hit) begin
                if (q.pos == LAST) begin
                    d.pos  = '0;
                    unlock = 1'b1;
                end else begin
                    d.pos = POS_W'(q.pos + 1'b1);
                end
            end else begin
                d.pos = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r2_mismatch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !clr && byte_in != key_at(q.pos)) |=> (q.pos == '0));

    a_r2_match_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !clr && byte_in == key_at(q.pos) && q.pos != LAST)
        |=> (q.pos == POS_W'($past(q.pos) + 1'b1)));

    a_r10_lock_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.pos == '0));

endmodule

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
    import cfg_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] idx,
    output fld_sel_t          sel
);
    always_comb begin
        sel.slot = 2'd0;
        unique case (idx)
            IDX_CSN:  sel.kind = FLD_CSN;
            IDX_LDN:  sel.kind = FLD_LDN;
            IDX_IO0:  sel.kind = FLD_IO;
            IDX_IO1:  begin sel.kind = FLD_IO;  sel.slot = 2'd1; end
            IDX_IO2:  begin sel.kind = FLD_IO;  sel.slot = 2'd2; end
            IDX_IRQ0: sel.kind = FLD_IRQ;
            IDX_IRQ1: begin sel.kind = FLD_IRQ; sel.slot = 2'd1; end
            IDX_DMA0: sel.kind = FLD_DMA;
            IDX_DMA1: begin sel.kind = FLD_DMA; sel.slot = 2'd1; end
            IDX_ACT:  sel.kind = FLD_ACT;
            default:  sel.kind = FLD_NONE;
        endcase
    end

    a_r9_slot_range: assert final (sel.slot != 2'd3);

endmodule

// File: rtl/cfg_seq_core.sv
module cfg_seq_core
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              unlock,
    input  fld_sel_t          sel_in,
    output logic              key_vld,
    output logic              in_config,
    output logic              csn_strobe,
    output logic [BYTE_W-1:0] csn_value,
    output logic              commit_strobe,
    output dev_rec_t          commit_rec
);
    typedef struct packed {
        seq_state_e        state;
        fld_sel_t          sel;
        dev_rec_t          pend;
        logic              pend_vld;
        logic              csn_stb;
        logic [BYTE_W-1:0] csn_val;
        logic              com_stb;
        dev_rec_t          com_rec;
    } core_t;

    core_t q, d;

    always_comb begin
        d         = q;
        d.csn_stb = 1'b0;
        d.com_stb = 1'b0;
        key_vld   = wr_en && !lock && (q.state == ST_IDLE);

        if (lock) begin
            d.state = ST_IDLE;
        end else if (wr_en) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (unlock) begin
                        d.state    = ST_INDEX;
                        d.pend     = '0;
                        d.pend_vld = 1'b0;
                    end
                end
                ST_INDEX: begin
                    if (wr_data == CMD_LEAVE) begin
                        if (q.pend_vld) begin
                            d.com_stb = 1'b1;
                            d.com_rec = q.pend;
                        end
                        d.pend_vld = 1'b0;
                        d.state    = ST_IDLE;
                    end else begin
                        d.sel   = sel_in;
                        d.state = ST_VAL;
                    end
                end
                ST_VAL: begin
                    d.state = ST_INDEX;
                    unique case (q.sel.kind)
                        FLD_CSN: begin
                            d.csn_stb = 1'b1;
                            d.csn_val = wr_data;
                        end
                        FLD_LDN: begin
                            if (q.pend_vld) begin
                                d.com_stb = 1'b1;
                                d.com_rec = q.pend;
                            end
                            d.pend     = '0;
                            d.pend.ldn = wr_data;
                            d.pend_vld = 1'b1;
                        end
                        FLD_IO: begin
                            if (q.pend_vld)
                                d.pend.io[q.sel.slot] = {wr_data, {(IO_W-BYTE_W){1'b0}}};
                            d.state = ST_VAL_LO;
                        end
                        FLD_IRQ: begin
                            if (q.pend_vld)
                                d.pend.irq[q.sel.slot[0]] = wr_data[IRQ_W-1:0];
                        end
                        FLD_DMA: begin
                            if (q.pend_vld)
                                d.pend.dma[q.sel.slot[0]] = wr_data[DMA_W-1:0];
                        end
                        FLD_ACT: begin
                            if (q.pend_vld)
                                d.pend.act = wr_data[0];
                        end
                        default: ;
                    endcase
                end
                ST_VAL_LO: begin
                    if (q.pend_vld)
                        d.pend.io[q.sel.slot][BYTE_W-1:0] = wr_data;
                    d.state = ST_INDEX;
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_config     = (q.state != ST_IDLE);
    assign csn_strobe    = q.csn_stb;
    assign csn_value     = q.csn_val;
    assign commit_strobe = q.com_stb;
    assign commit_rec    = q.com_rec;

    a_r10_lock_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !in_config);

    a_r3_leave_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_INDEX && wr_en && !lock && wr_data == CMD_LEAVE) |=> !in_config);

    a_r12_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_strobe |=> !commit_strobe);

    a_r8_commit_needs_record: assert property (@(posedge clk) disable iff (!rst_n)
        commit_strobe |-> $past(q.pend_vld));

    a_r4_csn_from_port: assert property (@(posedge clk) disable iff (!rst_n)
        csn_strobe |-> ($past(wr_en) && $past(wr_data) == csn_value));

    a_r12_record_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_strobe |-> $stable(commit_rec));

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
    import cfg_seq_pkg::*;
#(
    parameter int          KEY_LEN   = 32,
    parameter logic [7:0]  KEY_SEED0 = 8'h96,
    parameter logic [7:0]  KEY_SEED1 = 8'h35
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_lock,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic        in_config,
    output logic        csn_strobe,
    output logic [7:0]  csn_value,
    output logic        commit_strobe,
    output logic [7:0]  commit_ldn,
    output logic [15:0] commit_io0,
    output logic [15:0] commit_io1,
    output logic [15:0] commit_io2,
    output logic [3:0]  commit_irq0,
    output logic [3:0]  commit_irq1,
    output logic [2:0]  commit_dma0,
    output logic [2:0]  commit_dma1,
    output logic        commit_active
);
    logic     key_vld;
    logic     unlock;
    fld_sel_t sel;
    dev_rec_t rec;

    cfg_key_match #(
        .KEY_LEN   (KEY_LEN),
        .KEY_SEED0 (KEY_SEED0),
        .KEY_SEED1 (KEY_SEED1)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_lock),
        .byte_vld (key_vld),
        .byte_in  (wr_data),
        .unlock   (unlock)
    );

    cfg_index_decode u_dec (
        .idx (wr_data),
        .sel (sel)
    );

    cfg_seq_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock          (cfg_lock),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .unlock        (unlock),
        .sel_in        (sel),
        .key_vld       (key_vld),
        .in_config     (in_config),
        .csn_strobe    (csn_strobe),
        .csn_value     (csn_value),
        .commit_strobe (commit_strobe),
        .commit_rec    (rec)
    );

    assign commit_ldn    = rec.ldn;
    assign commit_io0    = rec.io[0];
    assign commit_io1    = rec.io[1];
    assign commit_io2    = rec.io[2];
    assign commit_irq0   = rec.irq[0];
    assign commit_irq1   = rec.irq[1];
    assign commit_dma0   = rec.dma[0];
    assign commit_dma1   = rec.dma[1];
    assign commit_active = rec.act;

endmodule

// File: tb/cfg_unlock_seq_test.sv
module cfg_unlock_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_lock = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        in_config, csn_strobe, commit_strobe, commit_active;
    logic [7:0]  csn_value, commit_ldn;
    logic [15:0] commit_io0, commit_io1, commit_io2;
    logic [3:0]  commit_irq0, commit_irq1;
    logic [2:0]  commit_dma0, commit_dma1;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [7:0] KEY [32] = '{
        8'h96, 8'h35, 8'h9A, 8'hCD, 8'hE6, 8'hF3, 8'h79, 8'hBC,
        8'h5E, 8'hAF, 8'h57, 8'h2B, 8'h15, 8'h8A, 8'hC5, 8'hE2,
        8'hF1, 8'hF8, 8'h7C, 8'h3E, 8'h9F, 8'h4F, 8'h27, 8'h13,
        8'h09, 8'h84, 8'h42, 8'hA1, 8'hD0, 8'h68, 8'h34, 8'h1A};

    always #4 clk = ~clk;

    cfg_unlock_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_lock(cfg_lock), .wr_en(wr_en), .wr_data(wr_data),
        .in_config(in_config), .csn_strobe(csn_strobe), .csn_value(csn_value),
        .commit_strobe(commit_strobe), .commit_ldn(commit_ldn),
        .commit_io0(commit_io0), .commit_io1(commit_io1), .commit_io2(commit_io2),
        .commit_irq0(commit_irq0), .commit_irq1(commit_irq1),
        .commit_dma0(commit_dma0), .commit_dma1(commit_dma1), .commit_active(commit_active));

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic send_key();
        for (int i = 0; i < 32; i++) wr(KEY[i]);
    endtask

    function automatic logic [79:0] rec_now();
        return {1'b1, commit_strobe, commit_ldn, commit_io0, commit_io1, commit_io2,
                commit_irq0, commit_irq1, commit_dma0, commit_dma1, commit_active};
    endfunction

    task automatic chk_rec(input string tag, input logic [7:0] ldn, input logic [15:0] i0,
                           input logic [15:0] i1, input logic [15:0] i2, input logic [3:0] q0,
                           input logic [3:0] q1, input logic [2:0] d0, input logic [2:0] d1,
                           input logic a);
        logic [79:0] e;
        e = {1'b1, 1'b1, ldn, i0, i1, i2, q0, q1, d0, d1, a};
        chk(rec_now() == e, tag, rec_now(), e);
    endtask

    function automatic bit known_idx(input logic [7:0] v);
        return v inside {8'h06, 8'h15, 8'h47, 8'h48, 8'h42, 8'h22, 8'h27,
                         8'h2A, 8'h25, 8'h33, 8'h79};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int bad;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk({in_config, csn_strobe, commit_strobe} == 3'b000, "R1 reset idle",
            {in_config, csn_strobe, commit_strobe}, 0);

        // R2 key in order
        for (int i = 0; i < 31; i++) wr(KEY[i]);
        chk(in_config == 1'b0, "R2 locked after 31 bytes", in_config, 0);
        wr(KEY[31]);
        chk(in_config == 1'b1, "R2 open after 32 bytes", in_config, 1);

        // R3 leave with no record
        wr(8'h79);
        chk({in_config, commit_strobe} == 2'b00, "R3 leave without record", {in_config, commit_strobe}, 0);

        // R2 mismatch at every position
        for (int p = 0; p < 32; p++) begin
            for (int i = 0; i < p; i++) wr(KEY[i]);
            wr(KEY[p] ^ 8'h01);
            for (int i = 0; i < 31; i++) wr(KEY[i]);
            chk(in_config == 1'b0, $sformatf("R2 mismatch pos %0d not early", p), in_config, 0);
            wr(KEY[31]);
            chk(in_config == 1'b1, $sformatf("R2 mismatch pos %0d then key", p), in_config, 1);
            wr(8'h79);
        end

        // R2 mismatching byte equal to first key byte does not restart the match
        for (int i = 0; i < 5; i++) wr(KEY[i]);
        wr(KEY[0]);
        for (int i = 1; i < 32; i++) wr(KEY[i]);
        chk(in_config == 1'b0, "R2 mismatch not counted as start", in_config, 0);

        // R4 card select
        send_key();
        wr(8'h06); wr(8'h5C);
        chk({csn_strobe, csn_value} == {1'b1, 8'h5C}, "R4 csn write", {csn_strobe, csn_value}, {1'b1, 8'h5C});
        @(negedge clk);
        chk(csn_strobe == 1'b0, "R4 csn pulse one cycle", csn_strobe, 0);

        // R8 writes with no device, then R5 device select
        wr(8'h22); wr(8'h05);
        wr(8'h47); wr(8'h12); wr(8'h34);
        wr(8'h2A); wr(8'h03);
        wr(8'h33); wr(8'h01);
        chk({in_config, commit_strobe} == 2'b10, "R8 no-device writes consumed", {in_config, commit_strobe}, 2'b10);
        wr(8'h15); wr(8'h03);
        chk(commit_strobe == 1'b0, "R5 first select no commit", commit_strobe, 0);
        wr(8'h79);
        chk_rec("R8 R3 empty record for device 3", 8'h03, 0, 0, 0, 0, 0, 0, 0, 0);

        // R6 R7 R5 full device
        send_key();
        wr(8'h15); wr(8'h00);
        wr(8'h47); wr(8'h02); wr(8'h20);
        wr(8'h48); wr(8'h03); wr(8'h88);
        wr(8'h42); wr(8'h02); wr(8'h30);
        wr(8'h22); wr(8'hF5);
        wr(8'h27); wr(8'h1A);
        wr(8'h2A); wr(8'hFF);
        wr(8'h25); wr(8'h09);
        wr(8'h33); wr(8'h03);
        wr(8'h15);
        chk(commit_strobe == 1'b0, "R12 no commit on index byte", commit_strobe, 0);
        wr(8'h01);
        chk_rec("R5 R6 R7 commit device 0", 8'h00, 16'h0220, 16'h0388, 16'h0230, 4'h5, 4'hA, 3'h7, 3'h1, 1'b1);
        @(negedge clk);
        chk({commit_strobe, commit_ldn, commit_io1} == {1'b0, 8'h00, 16'h0388}, "R12 record holds",
            {commit_strobe, commit_ldn, commit_io1}, {1'b0, 8'h00, 16'h0388});
        wr(8'h47); wr(8'hAB); wr(8'hCD);
        wr(8'h79);
        chk_rec("R3 R5 commit device 1 on leave", 8'h01, 16'hABCD, 0, 0, 0, 0, 0, 0, 0);

        // R9 sweep of unused indices
        send_key();
        wr(8'h15); wr(8'h07);
        bad = 0;
        for (int k = 0; k < 256; k++) begin
            v = 8'(k);
            if (!known_idx(v)) begin
                wr(v); wr(8'hFF);
                if (csn_strobe || commit_strobe || !in_config) bad++;
            end
        end
        chk(bad == 0, "R9 unused indices no effect", bad, 0);
        wr(8'h79);
        chk_rec("R9 record untouched", 8'h07, 0, 0, 0, 0, 0, 0, 0, 0);

        // R7 sweep of all value bytes through the narrow fields
        send_key();
        wr(8'h15); wr(8'h00);
        for (int k = 0; k < 256; k++) begin
            v = 8'(k);
            wr(8'h22); wr(v);
            wr(8'h27); wr(~v);
            wr(8'h2A); wr(v);
            wr(8'h25); wr(~v);
            wr(8'h33); wr(v);
            wr(8'h15); wr(8'h00);
            chk_rec($sformatf("R7 field masks value %0h", v), 8'h00, 0, 0, 0,
                    v[3:0], ~v[3:0], v[2:0], ~v[2:0], v[0]);
        end
        wr(8'h79);

        // R10 lock during session, R11 unlock discards pending record
        send_key();
        wr(8'h15); wr(8'h04);
        wr(8'h22); wr(8'h03);
        @(negedge clk); cfg_lock = 1'b1;
        @(negedge clk);
        chk(in_config == 1'b0, "R10 lock closes session", in_config, 0);
        send_key();
        chk(in_config == 1'b0, "R10 key ignored while locked", in_config, 0);
        cfg_lock = 1'b0;
        send_key();
        chk(in_config == 1'b1, "R10 unlock after release", in_config, 1);
        wr(8'h79);
        chk({in_config, commit_strobe} == 2'b00, "R11 pending record discarded",
            {in_config, commit_strobe}, 0);

        // R10 lock mid-key restarts matching
        for (int i = 0; i < 10; i++) wr(KEY[i]);
        @(negedge clk); cfg_lock = 1'b1;
        @(negedge clk); cfg_lock = 1'b0;
        for (int i = 10; i < 32; i++) wr(KEY[i]);
        chk(in_config == 1'b0, "R10 partial key lost on lock", in_config, 0);
        send_key();
        chk(in_config == 1'b1, "R10 fresh key after lock", in_config, 1);
        wr(8'h79);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule